// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a system clock into a one-cycle enable pulse at sixteen times the serial bit rate. That pulse is the oversample tick that the transmit and receive logic of a serial port use. The divisor has a 16-bit integer part and a 6-bit fraction counted in 1/64 steps. The mean tick period is therefore `IDIV + FDIV/64` clocks, and the bit rate is the clock divided by sixteen times that figure. For example, a 48 MHz clock with IDIV = 3 and FDIV = 16 gives a divisor of 3.25 and a bit rate near 923,077.

Software writes the integer and the fraction into two staging registers. Neither write alters the running rate. The running rate changes only when the line-control register is written. That write copies both staged divisor fields and the new line-control byte into the active set in one clock. The same edge restarts the period counter and clears the fraction phase, so the new rate governs from the very next tick.

To spread the fraction, a 6-bit phase accumulator adds FDIV at every tick. Whenever that sum carries out, the following tick period is one clock longer. While the active integer divisor is zero, the generator stays idle.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset, `tick` and `lcr_q` are 0, and the active integer divisor is zero, so no tick occurs until a commit.
- R2: A pulse on `idiv_wr` or `fdiv_wr` without `lcr_wr` changes neither the tick spacing nor `lcr_q`.
- R3: On a clock edge with `lcr_wr` high, the active divisor takes the staged IDIV and FDIV as they stood before that edge. A staging write in the same cycle is held for a later commit.
- R4: A commit restarts the period. The first tick is high in the IDIV-th cycle after the commit edge, where cycle 1 begins at that edge.
- R5: With IDIV >= 2, `tick` lasts exactly one cycle. Consecutive ticks are always IDIV or IDIV+1 clocks apart.
- R6: The phase accumulator is 6 bits wide and starts at 0 on a commit. At each tick it adds FDIV. A carry out lengthens the following period by one clock.
- R7: Any 64 consecutive tick periods total exactly 64*IDIV + FDIV clocks.
- R8: While the active IDIV is 0, `tick` stays low.
- R9: With IDIV = 1 and FDIV = 0, `tick` is high in every cycle after the commit edge.
- R10: `lcr_q` shows the line-control byte captured by the most recent commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idiv_wr | input | 1 | Write strobe for the staged integer divisor |
| idiv_wdata | input | 16 | Integer divisor value |
| fdiv_wr | input | 1 | Write strobe for the staged fractional divisor |
| fdiv_wdata | input | 6 | Fractional divisor, in units of 1/64 |
| lcr_wr | input | 1 | Line-control write strobe; commits all fields |
| lcr_wdata | input | 8 | Line-control byte |
| tick | output | 1 | One-cycle oversample enable |
| lcr_q | output | 8 | Committed line-control byte |

## Verification
The generator is tried with the following divisor patterns:
- A whole divisor of 4. This shows plain integer spacing.
- 3 + 16/64. This separates correct carry placement from a missing or misplaced stretch, since the 64-period total must equal 208 clocks.
- 1 + 0/64 and 1 + 63/64. These push the counter to its shortest period and the accumulator to its densest carry pattern.
- A divisor of zero. This must silence the output.

Further commits are made mid-period and in the same cycle as a staging write. These tell a restarting, snapshot-taking commit apart from one that keeps the old phase or forwards fresh data. Staging writes with no commit confirm that the running rate stays isolated until a commit.

// File: rtl/baud_pkg.sv
package baud_pkg;

    // Default field widths shared by the generator and its checker
    localparam int DEF_IDIV_W = 16;
    localparam int DEF_FDIV_W = 6;
    localparam int DEF_LCR_W  = 8;

    // Phase step: returns {carry, new_phase}
    function automatic logic [DEF_FDIV_W:0] phase_step(
        input logic [DEF_FDIV_W-1:0] phase,
        input logic [DEF_FDIV_W-1:0] step
    );
        return {1'b0, phase} + {1'b0, step};
    endfunction

endpackage

// File: rtl/baud_div_stage.sv
module baud_div_stage #(
    parameter int IW = 16,
    parameter int FW = 6,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idiv_wr,
    input  logic [IW-1:0] idiv_wdata,
    input  logic          fdiv_wr,
    input  logic [FW-1:0] fdiv_wdata,
    input  logic          lcr_wr,
    input  logic [LW-1:0] lcr_wdata,
    output logic [IW-1:0] act_idiv,
    output logic [FW-1:0] act_fdiv,
    output logic [LW-1:0] act_lcr
);

    typedef struct packed {
        logic [IW-1:0] stg_idiv;
        logic [FW-1:0] stg_fdiv;
        logic [IW-1:0] run_idiv;
        logic [FW-1:0] run_fdiv;
        logic [LW-1:0] run_lcr;
    } stage_t;

    stage_t stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        // Commit samples the staging registers as they stood before this edge
        if (lcr_wr) begin
            stage_d.run_idiv = stage_q.stg_idiv;
            stage_d.run_fdiv = stage_q.stg_fdiv;
            stage_d.run_lcr  = lcr_wdata;
        end
        if (idiv_wr) stage_d.stg_idiv = idiv_wdata;
        if (fdiv_wr) stage_d.stg_fdiv = fdiv_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign act_idiv = stage_q.run_idiv;
    assign act_fdiv = stage_q.run_fdiv;
    assign act_lcr  = stage_q.run_lcr;

endmodule

// File: rtl/baud_tick_core.sv
module baud_tick_core
    import baud_pkg::*;
#(
    parameter int IW = 16,
    parameter int FW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [IW-1:0] idiv,
    input  logic [FW-1:0] fdiv,
    output logic          tick
);

    typedef struct packed {
        logic [IW-1:0] cnt;
        logic [FW-1:0] phase;
        logic          stretch;
    } core_t;

    core_t core_d, core_q;

    logic          live;
    logic [IW:0]   last_cnt;
    logic          hit;
    logic [FW:0]   sum;

    always_comb begin
        live     = (idiv != '0);
        // Final count of this period: idiv - 1, plus one when stretched
        last_cnt = {1'b0, idiv} - {{IW{1'b0}}, 1'b1} + {{IW{1'b0}}, core_q.stretch};
        hit      = live && ({1'b0, core_q.cnt} == last_cnt);
        sum      = {1'b0, core_q.phase} + {1'b0, fdiv};

        core_d = core_q;
        if (restart || !live) begin
            core_d = '0;
        end else if (hit) begin
            core_d.cnt     = '0;
            core_d.phase   = sum[FW-1:0];
            core_d.stretch = sum[FW];
        end else begin
            core_d.cnt = core_q.cnt + {{(IW-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign tick = hit;

endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
    import baud_pkg::*;
#(
    parameter int IDIV_W = DEF_IDIV_W,
    parameter int FDIV_W = DEF_FDIV_W,
    parameter int LCR_W  = DEF_LCR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idiv_wr,
    input  logic [IDIV_W-1:0] idiv_wdata,
    input  logic              fdiv_wr,
    input  logic [FDIV_W-1:0] fdiv_wdata,
    input  logic              lcr_wr,
    input  logic [LCR_W-1:0]  lcr_wdata,
    output logic              tick,
    output logic [LCR_W-1:0]  lcr_q
);

    logic [IDIV_W-1:0] act_idiv;
    logic [FDIV_W-1:0] act_fdiv;

    baud_div_stage #(.IW(IDIV_W), .FW(FDIV_W), .LW(LCR_W)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .idiv_wr    (idiv_wr),
        .idiv_wdata (idiv_wdata),
        .fdiv_wr    (fdiv_wr),
        .fdiv_wdata (fdiv_wdata),
        .lcr_wr     (lcr_wr),
        .lcr_wdata  (lcr_wdata),
        .act_idiv   (act_idiv),
        .act_fdiv   (act_fdiv),
        .act_lcr    (lcr_q)
    );

    baud_tick_core #(.IW(IDIV_W), .FW(FDIV_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (lcr_wr),
        .idiv    (act_idiv),
        .fdiv    (act_fdiv),
        .tick    (tick)
    );

endmodule

// File: rtl/baud_frac_gen_chk.sv
module baud_frac_gen_chk #(
    parameter int IW = 16,
    parameter int FW = 6,
    parameter int LW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          idiv_wr,
    input logic          fdiv_wr,
    input logic          lcr_wr,
    input logic [LW-1:0] lcr_wdata,
    input logic [LW-1:0] lcr_q,
    input logic [IW-1:0] act_idiv,
    input logic [FW-1:0] act_fdiv,
    input logic          tick
);

    p_zero_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_idiv == '0) |-> !tick);

    p_commit_lcr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lcr_wr |=> (lcr_q == $past(lcr_wdata)));

    p_hold_lcr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lcr_wr |=> $stable(lcr_q));

    p_hold_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lcr_wr |=> ($stable(act_idiv) && $stable(act_fdiv)));

    p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !lcr_wr && act_idiv >= 2) |=> !tick);

    p_every_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_idiv == 1 && act_fdiv == '0) |-> tick);

    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lcr_wr |=> (act_idiv < 2 || !tick));

endmodule

bind baud_frac_gen baud_frac_gen_chk #(.IW(IDIV_W), .FW(FDIV_W), .LW(LCR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .idiv_wr   (idiv_wr),
    .fdiv_wr   (fdiv_wr),
    .lcr_wr    (lcr_wr),
    .lcr_wdata (lcr_wdata),
    .lcr_q     (lcr_q),
    .act_idiv  (act_idiv),
    .act_fdiv  (act_fdiv),
    .tick      (tick)
);

// File: tb/tb_baud_frac_gen.sv
`timescale 1ns/1ps
module tb_baud_frac_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idiv_wr = 1'b0;
    logic [15:0] idiv_wdata = '0;
    logic        fdiv_wr = 1'b0;
    logic [5:0]  fdiv_wdata = '0;
    logic        lcr_wr = 1'b0;
    logic [7:0]  lcr_wdata = '0;
    logic        tick;
    logic [7:0]  lcr_q;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    string cur_req = "R1";

    // Expected-schedule state, built from R3, R4, R6
    int m_i = 0, m_f = 0, m_j = 0, m_next = 0, m_acc = 0;
    int st_i = 0, st_f = 0;
    bit chk_en = 1'b0;

    always #4 clk = ~clk;

    baud_frac_gen dut (
        .clk(clk), .rst_n(rst_n),
        .idiv_wr(idiv_wr), .idiv_wdata(idiv_wdata),
        .fdiv_wr(fdiv_wr), .fdiv_wdata(fdiv_wdata),
        .lcr_wr(lcr_wr), .lcr_wdata(lcr_wdata),
        .tick(tick), .lcr_q(lcr_q)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Per-cycle comparison of tick against the expected schedule
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_t;
            int s;
            m_j++;
            exp_t = (m_i != 0) && (m_j == m_next);
            if (chk_en) chk(tick === exp_t, cur_req, int'(tick), int'(exp_t));
            if (exp_t) begin
                s      = m_acc + m_f;
                m_acc  = s % 64;
                m_next = m_j + m_i + s / 64;
            end
            if (lcr_wr) begin
                m_i = st_i; m_f = st_f; m_j = 0; m_acc = 0; m_next = st_i;
            end
            if (idiv_wr) st_i = int'(idiv_wdata);
            if (fdiv_wr) st_f = int'(fdiv_wdata);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic stage_i(input int v);
        idiv_wr = 1'b1; idiv_wdata = 16'(v); step(); idiv_wr = 1'b0;
    endtask

    task automatic stage_f(input int v);
        fdiv_wr = 1'b1; fdiv_wdata = 6'(v); step(); fdiv_wr = 1'b0;
    endtask

    task automatic commit(input int v);
        lcr_wr = 1'b1; lcr_wdata = 8'(v); step(); lcr_wr = 1'b0;
    endtask

    task automatic count_ticks(input int n, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (tick) c++;
        end
    endtask

    task automatic first_tick_at(input int lim, output int pos);
        pos = -1;
        for (int k = 1; k <= lim; k++) begin
            @(negedge clk);
            if (tick && pos < 0) pos = k;
        end
    endtask

    task automatic t_reset();
        int c;
        cur_req = "R1";
        @(negedge clk);
        chk(tick == 1'b0, "R1", int'(tick), 0);
        chk(lcr_q == 8'h00, "R1", int'(lcr_q), 0);
        count_ticks(40, c);
        chk(c == 0, "R1", c, 0);
    endtask

    task automatic t_stage_no_commit();
        int c;
        cur_req = "R2";
        step();
        stage_i(4); stage_f(0);
        count_ticks(30, c);
        chk(c == 0, "R2", c, 0);
        chk(lcr_q == 8'h00, "R2", int'(lcr_q), 0);
    endtask

    task automatic t_integer();
        int c;
        cur_req = "R4";
        step();
        commit(8'h60);
        count_ticks(40, c);
        chk(c == 10, "R4", c, 10);
        chk(lcr_q == 8'h60, "R10", int'(lcr_q), 8'h60);
    endtask

    task automatic t_stage_hold();
        int gap;
        cur_req = "R2";
        step();
        stage_i(9); stage_f(5);
        @(negedge clk);
        while (!tick) @(negedge clk);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!tick);
        chk(gap == 4, "R2", gap, 4);
        chk(lcr_q == 8'h60, "R2", int'(lcr_q), 8'h60);
    endtask

    task automatic t_fraction();
        int t1, t65, n;
        cur_req = "R6";
        step();
        stage_i(3); stage_f(16);
        commit(8'h70);
        t1 = -1; t65 = -1; n = 0;
        for (int k = 1; k <= 400; k++) begin
            @(negedge clk);
            if (tick) begin
                n++;
                if (n == 1)  t1 = k;
                if (n == 65) t65 = k;
            end
        end
        chk(t1 == 3, "R4", t1, 3);
        chk(t65 - t1 == 208, "R7", t65 - t1, 208);
    endtask

    task automatic t_unit();
        int c;
        cur_req = "R9";
        step();
        stage_i(1); stage_f(0);
        commit(8'h11);
        count_ticks(20, c);
        chk(c == 20, "R9", c, 20);
        cur_req = "R6";
        stage_f(63);
        commit(8'h12);
        count_ticks(127, c);
        chk(c == 64, "R7", c, 64);
    endtask

    task automatic t_restart();
        int pos;
        cur_req = "R4";
        step();
        stage_i(10); stage_f(0);
        commit(8'h21);
        repeat (5) step();
        stage_i(6);
        commit(8'h22);
        first_tick_at(6, pos);
        chk(pos == 6, "R4", pos, 6);
    endtask

    task automatic t_same_cycle();
        int pos;
        cur_req = "R3";
        step();
        idiv_wr = 1'b1; idiv_wdata = 16'd2;
        lcr_wr = 1'b1;  lcr_wdata = 8'h3C;
        step();
        idiv_wr = 1'b0; lcr_wr = 1'b0;
        first_tick_at(6, pos);
        chk(pos == 6, "R3", pos, 6);
        chk(lcr_q == 8'h3C, "R10", int'(lcr_q), 8'h3C);
        step();
        commit(8'h3D);
        first_tick_at(2, pos);
        chk(pos == 2, "R3", pos, 2);
    endtask

    task automatic t_zero();
        int c;
        cur_req = "R8";
        step();
        stage_i(0);
        commit(8'h05);
        count_ticks(100, c);
        chk(c == 0, "R8", c, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_en = 1'b1;
        t_reset();
        t_stage_no_commit();
        t_integer();
        t_stage_hold();
        t_fraction();
        t_unit();
        t_restart();
        t_same_cycle();
        t_zero();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule